// File: doc/BRIEF.md
# Up/Down Position Counter with Step and Revolution Pulses

This block is the digital back end of a tracking position converter. Upstream logic sends one increment or decrement request for every least-significant-bit movement of the tracked angle. The block keeps a wrapping up/down position count and a direction level. It gives every serviced step a BUSY strobe, and an output latch elsewhere loads the position word on that strobe. A RIPPLE flag goes high whenever the count passes through its major carry, and that marks one full revolution or pitch.

Each step runs through a four-state sequencer. `ST_IDLE` waits for queued work and takes one step through the transition *take*. `ST_DIR` holds the newly chosen direction level and leaves through *advance*, where the count moves and the wrap is judged. `ST_SETTLE` holds the new count and leaves through *strobe*, where BUSY rises. `ST_PULSE` keeps BUSY high for a parameterised number of cycles and returns through *release*. Requests that arrive while a step is in flight collect in a signed net backlog. For an external turns counter, a pair of gated strobes marks only the steps that actually wrapped. These strobes never fire for a RIPPLE level that is merely being held.

Timing parameters are given in picoseconds and converted to clock cycles. With the defaults (5 ns clock, 400 ns BUSY, 300 ns minimum RIPPLE) BUSY lasts 80 cycles and RIPPLE at least 60.

Top module: `turn_tracker`

## Requirements
- R1: After reset the position is 0, the direction is up (dir = 1), and busy, ripple, rev_up and rev_dn are all 0.
- R2: Each serviced up step adds 1 to the position and each down step subtracts 1, modulo 2^W. Each serviced step gives exactly one busy pulse, and the position never changes while busy is high.
- R3: Busy stays high for exactly ceil(BUSY_PS / CLK_PS) cycles, which is 80 cycles by default.
- R4: The direction of a step (1 = up, 0 = down) appears on dir at the first edge after the step is taken. The position changes one edge later, and busy rises one edge after that.
- R5: A wrap sets ripple at the same edge as the position update. Up from all ones to 0 is a wrap, and so is down from 0 to all ones.
- R6: Ripple stays high for at least ceil(RIPPLE_PS / CLK_PS) cycles, which is 60 by default. Without a direction change it clears at the first edge with busy low after that width, so it is low at the next busy rise.
- R7: If dir changes while ripple is high, ripple stays high through the first two busy rises that follow with dir unchanged. After the second of these it clears by the R6 rule.
- R8: Requests that arrive while a step is in flight are queued as a net count. Each queued step starts three edges after busy falls. An up and a down request cancel each other, and up and down together in one cycle do nothing.
- R9: rev_up (or rev_dn) is a one-cycle pulse in the first busy cycle of a step that wrapped upward (or downward). Both stay 0 in every other cycle, including busy rises where ripple is only being held.
- R10: The backlog holds at most MAX_BACKLOG steps (4 by default) in either direction, and further requests in that direction are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_up | input | 1 | One-cycle request to move up one LSB |
| step_dn | input | 1 | One-cycle request to move down one LSB |
| pos | output | W | Position count |
| dir | output | 1 | Direction level, 1 = up |
| busy | output | 1 | Update strobe, one pulse per step |
| ripple | output | 1 | Revolution flag set on major carry |
| rev_up | output | 1 | Gated strobe for an upward revolution |
| rev_dn | output | 1 | Gated strobe for a downward revolution |

## Verification
Short runs in one direction followed by a reversal show whether the count, dir and the edge order of dir, position and busy behave when no carry is involved. A downward wrap and an upward wrap, each issued from idle, separate the two carry directions and the gated strobes, and they also show ripple clearing on time. A reversal queued during the busy pulse of a wrapping step is the only pattern that exercises the ripple hold, and a following step shows that the hold releases. Bursts of requests during busy cover cancellation, simultaneous requests and backlog saturation, where any extra or missing busy pulse shows up as a scoreboard mismatch.

// File: rtl/turn_tracker_pkg.sv
`timescale 1ns/1ps
package turn_tracker_pkg;

    // Step sequencer phases, one cycle each except ST_PULSE
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DIR    = 2'd1,
        ST_SETTLE = 2'd2,
        ST_PULSE  = 2'd3
    } seq_state_e;

    function automatic int ps_to_cycles(input int span_ps, input int clk_ps);
        return (span_ps + clk_ps - 1) / clk_ps;
    endfunction

endpackage

// File: rtl/step_backlog.sv
`timescale 1ns/1ps
module step_backlog #(
    parameter int MAX_BACKLOG = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_up,
    input  logic req_dn,
    input  logic take,
    output logic pending,
    output logic want_up
);
    localparam int BW = $clog2(MAX_BACKLOG + 1) + 1;

    logic signed [BW-1:0] net_q;
    logic signed [BW-1:0] net_d;
    int                   sum;

    always_comb begin
        sum = int'(net_q);
        if (take) begin
            sum = (net_q > 0) ? sum - 1 : sum + 1;
        end
        if (req_up && !req_dn) begin
            sum = sum + 1;
        end else if (req_dn && !req_up) begin
            sum = sum - 1;
        end
        if (sum > MAX_BACKLOG) begin
            sum = MAX_BACKLOG;
        end else if (sum < -MAX_BACKLOG) begin
            sum = -MAX_BACKLOG;
        end
        net_d = BW'(sum);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            net_q <= '0;
        end else begin
            net_q <= net_d;
        end
    end

    assign pending = (net_q != 0);
    assign want_up = (net_q > 0);

    // R10: backlog never exceeds its limit in either direction
    p_backlog_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (net_q <= MAX_BACKLOG) && (net_q >= -MAX_BACKLOG));

    // R8: a take always removes work that was really queued
    p_take_nonempty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> pending);

endmodule

// File: rtl/pos_sequencer.sv
`timescale 1ns/1ps
module pos_sequencer
    import turn_tracker_pkg::*;
#(
    parameter int W        = 8,
    parameter int BUSY_CYC = 80
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pending,
    input  logic         want_up,
    output logic         take,
    output logic         dir_flip,
    output logic         wrap_now,
    output logic         rise_now,
    output logic [W-1:0] pos,
    output logic         dir,
    output logic         busy
);
    localparam int CW = $clog2(BUSY_CYC + 1);

    seq_state_e    state_q;
    seq_state_e    state_d;
    logic [CW-1:0] cnt_q;
    logic          last_beat;
    logic          step_now;

    assign last_beat = (cnt_q == CW'(BUSY_CYC - 1));
    assign take      = (state_q == ST_IDLE) && pending;
    assign dir_flip  = take && (want_up != dir);
    assign step_now  = (state_q == ST_DIR);
    assign rise_now  = (state_q == ST_SETTLE);
    assign wrap_now  = step_now && (dir ? (&pos) : (~|pos));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (pending)   state_d = ST_DIR;    // take
            ST_DIR:                   state_d = ST_SETTLE; // advance
            ST_SETTLE:                state_d = ST_PULSE;  // strobe
            ST_PULSE:  if (last_beat) state_d = ST_IDLE;   // release
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos   <= '0;
            dir   <= 1'b1;
            busy  <= 1'b0;
            cnt_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (take) begin
                        dir <= want_up;
                    end
                end
                ST_DIR: begin
                    pos <= dir ? pos + W'(1) : pos - W'(1);
                end
                ST_SETTLE: begin
                    busy  <= 1'b1;
                    cnt_q <= '0;
                end
                ST_PULSE: begin
                    cnt_q <= cnt_q + CW'(1);
                    if (last_beat) begin
                        busy <= 1'b0;
                    end
                end
            endcase
        end
    end

    // R2: every change of position is a single LSB
    p_single_lsb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pos) |-> (((pos - $past(pos)) == W'(1)) || (($past(pos) - pos) == W'(1))));

    // R2: the position holds while busy is high
    p_pos_quiet_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(pos));

    // R4: a direction change never coincides with a position change or busy
    p_dir_leads_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dir) |-> ($stable(pos) && !busy));

    // R4: busy rises with position and direction already settled
    p_busy_after_pos_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($stable(pos) && $stable(dir)));

endmodule

// File: rtl/ripple_flag.sv
`timescale 1ns/1ps
module ripple_flag #(
    parameter int RIP_CYC = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_now,
    input  logic busy,
    input  logic dir_flip,
    input  logic rise_now,
    output logic ripple
);
    localparam int AW = $clog2(RIP_CYC + 1);

    logic [AW-1:0] age_q;
    logic          hold_q;
    logic          seen_q;
    logic          wide_enough;

    assign wide_enough = (age_q >= AW'(RIP_CYC));

    // Flag and its age
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ripple <= 1'b0;
            age_q  <= '0;
        end else if (set_now) begin
            ripple <= 1'b1;
            age_q  <= AW'(1);
        end else if (ripple) begin
            if (!wide_enough) begin
                age_q <= age_q + AW'(1);
            end
            if (!dir_flip && wide_enough && !busy && !hold_q) begin
                ripple <= 1'b0;
            end
        end
    end

    // Hold after a direction change: release on the second stable busy rise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
            seen_q <= 1'b0;
        end else if (ripple && dir_flip) begin
            hold_q <= 1'b1;
            seen_q <= 1'b0;
        end else if (hold_q && rise_now) begin
            if (seen_q) begin
                hold_q <= 1'b0;
            end
            seen_q <= ~seen_q;
        end
    end

    // R6: ripple only clears once busy is low and no hold is pending
    p_clear_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ripple) |-> (!$past(busy) && !$past(hold_q)));

    // R7: while a hold is active, ripple stays high
    p_hold_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hold_q |-> ripple);

endmodule

// File: rtl/rev_gate.sv
`timescale 1ns/1ps
module rev_gate #(
    parameter bit EN = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_now,
    input  logic rise_now,
    input  logic dir,
    input  logic ripple,
    output logic rev_up,
    output logic rev_dn
);
    generate
        if (EN) begin : g_gate
            logic armed_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    armed_q <= 1'b0;
                    rev_up  <= 1'b0;
                    rev_dn  <= 1'b0;
                end else begin
                    rev_up <= 1'b0;
                    rev_dn <= 1'b0;
                    if (set_now) begin
                        armed_q <= 1'b1;
                    end else if (rise_now) begin
                        rev_up  <= armed_q && ripple && dir;
                        rev_dn  <= armed_q && ripple && !dir;
                        armed_q <= 1'b0;
                    end
                end
            end

            // R9: never both directions at once
            p_rev_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0({rev_up, rev_dn}));

            // R9: a strobe lasts a single cycle
            p_rev_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (rev_up || rev_dn) |=> !(rev_up || rev_dn));
        end else begin : g_off
            logic unused_in;
            assign unused_in = ^{clk, rst_n, set_now, rise_now, dir, ripple};
            assign rev_up    = 1'b0;
            assign rev_dn    = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/turn_tracker.sv
`timescale 1ns/1ps
module turn_tracker
    import turn_tracker_pkg::*;
#(
    parameter int W           = 8,
    parameter int CLK_PS      = 5000,
    parameter int BUSY_PS     = 400000,
    parameter int RIPPLE_PS   = 300000,
    parameter int MAX_BACKLOG = 4,
    parameter bit REV_EN      = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_up,
    input  logic         step_dn,
    output logic [W-1:0] pos,
    output logic         dir,
    output logic         busy,
    output logic         ripple,
    output logic         rev_up,
    output logic         rev_dn
);
    localparam int BUSY_CYC = ps_to_cycles(BUSY_PS, CLK_PS);
    localparam int RIP_CYC  = ps_to_cycles(RIPPLE_PS, CLK_PS);

    logic pending;
    logic want_up;
    logic take;
    logic dir_flip;
    logic wrap_now;
    logic rise_now;

    step_backlog #(.MAX_BACKLOG(MAX_BACKLOG)) u_backlog (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_up  (step_up),
        .req_dn  (step_dn),
        .take    (take),
        .pending (pending),
        .want_up (want_up)
    );

    pos_sequencer #(.W(W), .BUSY_CYC(BUSY_CYC)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .pending  (pending),
        .want_up  (want_up),
        .take     (take),
        .dir_flip (dir_flip),
        .wrap_now (wrap_now),
        .rise_now (rise_now),
        .pos      (pos),
        .dir      (dir),
        .busy     (busy)
    );

    ripple_flag #(.RIP_CYC(RIP_CYC)) u_ripple (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_now  (wrap_now),
        .busy     (busy),
        .dir_flip (dir_flip),
        .rise_now (rise_now),
        .ripple   (ripple)
    );

    rev_gate #(.EN(REV_EN)) u_rev (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_now  (wrap_now),
        .rise_now (rise_now),
        .dir      (dir),
        .ripple   (ripple),
        .rev_up   (rev_up),
        .rev_dn   (rev_dn)
    );

    // R1: first cycle out of reset shows the reset state
    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> ((pos == '0) && dir && !busy && !ripple && !rev_up && !rev_dn));

    // R5: ripple only rises on a position at the major carry
    p_wrap_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ripple) |-> ((pos == '0) || (&pos)));

    // R9: a revolution strobe sits inside busy with ripple high
    p_rev_inside_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rev_up || rev_dn) |-> (busy && ripple));

endmodule

// File: tb/sim_turn_tracker.sv
`timescale 1ns/1ps
module sim_turn_tracker;

    localparam int BUSY_CYC = 80;
    localparam int RIP_CYC  = 60;

    typedef struct packed {
        logic [7:0] old_pos;
        logic [7:0] new_pos;
        logic       up;
        logic       rip;
        logic       rup;
        logic       rdn;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       step_up = 1'b0;
    logic       step_dn = 1'b0;
    logic [7:0] pos;
    logic       dir, busy, ripple, rev_up, rev_dn;

    int   errs = 0;
    int   checks = 0;
    int   cyc = 0;
    bit   done = 1'b0;
    exp_t q[$];
    logic [7:0] m_pos = 8'h00;

    always #2.5 clk = ~clk;

    turn_tracker u0 (
        .clk(clk), .rst_n(rst_n), .step_up(step_up), .step_dn(step_dn),
        .pos(pos), .dir(dir), .busy(busy), .ripple(ripple),
        .rev_up(rev_up), .rev_dn(rev_dn)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
        end
    endtask

    // Driver side: model the step and queue what the monitor must see
    task automatic expect_step(input bit up, input bit held);
        exp_t e;
        bit   wrap;
        wrap      = up ? (m_pos == 8'hFF) : (m_pos == 8'h00);
        e.old_pos = m_pos;
        m_pos     = up ? m_pos + 8'd1 : m_pos - 8'd1;
        e.new_pos = m_pos;
        e.up      = up;
        e.rip     = wrap || held;
        e.rup     = wrap && up;
        e.rdn     = wrap && !up;
        q.push_back(e);
    endtask

    task automatic pulse(input bit up, input bit dn);
        @(negedge clk);
        step_up = up;
        step_dn = dn;
        @(negedge clk);
        step_up = 1'b0;
        step_dn = 1'b0;
    endtask

    task automatic wait_done();
        int t;
        t = 0;
        while (q.size() != 0 && t < 4000) begin
            @(negedge clk);
            t++;
        end
        chk(q.size() == 0, "R2 missing busy pulse", q.size(), 0);
        q.delete();
        repeat (BUSY_CYC + 12) @(negedge clk);
    endtask

    // Monitor: compare each busy rise against the scoreboard
    logic       b_prev = 1'b0, r_prev = 1'b0;
    logic [7:0] h1_pos = 8'h00, h2_pos = 8'h00;
    logic       h1_dir = 1'b1, h2_dir = 1'b1;
    int         bw = 0, rw = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (busy && !b_prev) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R2 extra busy pulse", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(pos == e.new_pos, "R2 position", pos, e.new_pos);
                    chk(dir == e.up, "R2 direction", dir, e.up);
                    chk(h1_pos == e.new_pos, "R4 position before busy", h1_pos, e.new_pos);
                    chk(h2_pos == e.old_pos, "R4 position two cycles before busy", h2_pos, e.old_pos);
                    chk(h2_dir == e.up, "R4 dir ahead of position", h2_dir, e.up);
                    if (e.rup || e.rdn)
                        chk(ripple == 1'b1, "R5 ripple on wrap", ripple, 1);
                    else if (e.rip)
                        chk(ripple == 1'b1, "R7 ripple held", ripple, 1);
                    else
                        chk(ripple == 1'b0, "R6 ripple low at busy rise", ripple, 0);
                    chk(rev_up == e.rup, "R9 rev_up", rev_up, e.rup);
                    chk(rev_dn == e.rdn, "R9 rev_dn", rev_dn, e.rdn);
                end
            end else if (rev_up || rev_dn) begin
                chk(1'b0, "R9 strobe outside busy rise", {rev_up, rev_dn}, 0);
            end
            if (busy) bw++;
            if (!busy && b_prev) begin
                chk(bw == BUSY_CYC, "R3 busy width", bw, BUSY_CYC);
                bw = 0;
            end
            if (ripple) rw++;
            if (!ripple && r_prev) begin
                chk(rw >= RIP_CYC, "R6 ripple width", rw, RIP_CYC);
                rw = 0;
            end
        end
        b_prev = busy;
        r_prev = ripple;
        h2_pos = h1_pos;
        h1_pos = pos;
        h2_dir = h1_dir;
        h1_dir = dir;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 60000 && !done) begin
            errs++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 60000);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(pos == 8'h00, "R1 pos", pos, 0);
        chk(dir == 1'b1, "R1 dir", dir, 1);
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(ripple == 1'b0, "R1 ripple", ripple, 0);
        chk({rev_up, rev_dn} == 2'b00, "R1 rev", {rev_up, rev_dn}, 0);

        // R2/R4: plain up run, then a reversal away from the carry
        for (int i = 0; i < 3; i++) begin
            pulse(1, 0); expect_step(1, 0); wait_done();
        end
        for (int i = 0; i < 3; i++) begin
            pulse(0, 1); expect_step(0, 0); wait_done();
        end
        // R5: downward wrap 0 -> FF, then upward wrap FF -> 0
        pulse(0, 1); expect_step(0, 0); wait_done();
        pulse(1, 0); expect_step(1, 0); wait_done();

        // R7: reversal queued during the busy of a wrapping step
        pulse(0, 1); expect_step(0, 0);
        wait (busy);
        pulse(1, 0); expect_step(1, 0);
        wait_done();
        pulse(1, 0); expect_step(1, 1); wait_done();
        pulse(1, 0); expect_step(1, 0); wait_done();

        // R8: opposite requests while busy cancel out
        pulse(1, 0); expect_step(1, 0);
        wait (busy);
        pulse(1, 0);
        pulse(0, 1);
        wait_done();
        chk(pos == 8'h03, "R8 cancelled requests", pos, 3);
        // R8: both requests in one cycle do nothing
        pulse(1, 1);
        wait_done();
        chk(pos == 8'h03, "R8 simultaneous requests", pos, 3);

        // R10: burst beyond the backlog limit
        pulse(1, 0);
        for (int i = 0; i < 5; i++) expect_step(1, 0);
        wait (busy);
        for (int i = 0; i < 6; i++) pulse(1, 0);
        wait_done();
        chk(pos == 8'h08, "R10 saturated backlog", pos, 8);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule